// File: doc/BRIEF.md
# Instruction Queue Reconstruction Tracker

This block sits beside the bus of a 16-bit processor and rebuilds, from bus observation alone, the processor's internal instruction prefetch queue. It watches the address bus, the 16-bit data bus, the read/write strobe, the bus clock E and a two-bit pipe status pair. The status pair is time-multiplexed. When E rises it carries a data-movement code. When E falls it carries an execution-start code.

The rebuilt queue has a holding latch, a first stage and a second stage. Every entry keeps the fetch address of its word next to the word. When the processor starts an instruction, the tracker reports the opcode byte, the address of that byte, and whether the start was even or odd. An interrupt start gives a separate one-cycle pulse. A start that finds no valid word in the second stage gives an error pulse instead of a report.

All logic runs on a fast system clock that oversamples E. E passes through a synchronizer. The address, data, read/write and status inputs are delayed by the same number of flops, so they stay aligned with E. Each E edge then becomes a single-cycle strobe.

Top module: `iq_tracker`

## Requirements
- R1: After reset every queue entry is invalid and all output pulses are low. A start code that arrives before any word has been loaded gives a start error.
- R2: At each E falling edge, address, data and rw_i are captured together, with rw_i=1 meaning a read. A word captured in a write cycle is marked invalid. When it reaches the second stage, an even or odd start gives an error rather than an opcode.
- R3: Movement code 01 (E rising) copies the captured word into the holding latch and leaves both queue stages unchanged.
- R4: Movement code 10 (E rising) moves the first stage into the second stage and loads the first stage from the captured word.
- R5: Movement code 11 (E rising) moves the first stage into the second stage and loads the first stage from the holding latch. The latch then becomes invalid, so a second use before it is refilled loads an invalid word.
- R6: Movement code 00 leaves the latch and both stages unchanged.
- R7: Start code 10 (E falling) reports the high byte (bits 15:8) of the second-stage word, with the word's address, and sets op_odd_o=0.
- R8: Start code 11 (E falling) reports the low byte (bits 7:0) of the second-stage word, with the word's address plus one, and sets op_odd_o=1.
- R9: Start code 01 gives a one-cycle irq_start_o pulse and no opcode report.
- R10: An even or odd start while the second stage is invalid gives a one-cycle start_err_o pulse and no opcode report.
- R11: Start code 00 gives no pulse on any output.
- R12: Each report, interrupt pulse or error pulse lasts exactly one clk_i cycle. It appears on the third rising clk_i edge after the E transition at e_i. At most one of the three pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock, oversamples E |
| rst_ni | input | 1 | Asynchronous reset, active low |
| e_i | input | 1 | Bus clock E, asynchronous to clk_i |
| rw_i | input | 1 | Read/write strobe, 1 = read |
| pipe_i | input | 2 | Pipe status pair (movement code on E rise, start code on E fall) |
| addr_i | input | ADDR_W (16) | Bus address |
| data_i | input | DATA_W (16) | Bus data word |
| op_valid_o | output | 1 | One-cycle opcode report strobe |
| op_byte_o | output | DATA_W/2 (8) | Reported opcode byte |
| op_addr_o | output | ADDR_W (16) | Address of the reported opcode byte |
| op_odd_o | output | 1 | 1 = odd start, 0 = even start |
| irq_start_o | output | 1 | One-cycle interrupt-start pulse |
| start_err_o | output | 1 | One-cycle pulse: start with an invalid second stage |

## Verification
A wrong queue state stays hidden until the next start code, because the stages are only visible through the opcode report. A stage that was wrongly shifted or loaded therefore shows up one or two E cycles later, as a wrong opcode byte, a wrong address, or an error pulse where a report was expected (or the reverse). The bench walks words through the latch and both stages with distinct data and address patterns, so that any mix-up between sources produces a distinct wrong byte or address. It also counts the pulses in a fixed window after every E edge, so that a missing, doubled or late strobe is caught within that edge.

// File: rtl/iqt_pkg.sv
package iqt_pkg;

  typedef enum logic [1:0] {
    MV_NONE      = 2'b00,
    MV_LATCH     = 2'b01,
    MV_ADV_BUS   = 2'b10,
    MV_ADV_LATCH = 2'b11
  } move_e;

  typedef enum logic [1:0] {
    ST_NONE = 2'b00,
    ST_IRQ  = 2'b01,
    ST_EVEN = 2'b10,
    ST_ODD  = 2'b11
  } start_e;

endpackage

// File: rtl/iqt_edge_sync.sv
module iqt_edge_sync #(
  parameter int STAGES = 2,
  parameter int PW     = 35
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          e_i,
  input  logic [PW-1:0] payload_i,
  output logic          rise_stb_o,
  output logic          fall_stb_o,
  output logic [PW-1:0] payload_o
);

  logic [STAGES:0] e_q;
  logic [PW-1:0]   p_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) e_q <= '0;
    else         e_q <= {e_q[STAGES-1:0], e_i};
  end

  // payload delayed to line up with e_q[STAGES-1]
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p_q[0] <= '0;
    else         p_q[0] <= payload_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) p_q[k] <= '0;
      else         p_q[k] <= p_q[k-1];
    end
  end

  assign rise_stb_o = e_q[STAGES-1] & ~e_q[STAGES];
  assign fall_stb_o = ~e_q[STAGES-1] & e_q[STAGES];
  assign payload_o  = p_q[STAGES-1];

  // R12
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_stb_o |=> !rise_stb_o);
  // R12
  fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_stb_o |=> !fall_stb_o);

endmodule

// File: rtl/iqt_bus_capture.sv
module iqt_bus_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_stb_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              cap_v_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [DATA_W-1:0] cap_data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_v_o    <= 1'b0;
      cap_addr_o <= '0;
      cap_data_o <= '0;
    end else if (fall_stb_i) begin
      cap_v_o    <= rd_i;
      cap_addr_o <= addr_i;
      cap_data_o <= data_i;
    end
  end

  // R2
  write_not_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_stb_i && !rd_i) |=> !cap_v_o);
  // R2
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_stb_i |=> $stable(cap_v_o) && $stable(cap_data_o));

endmodule

// File: rtl/iqt_queue.sv
module iqt_queue
  import iqt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_stb_i,
  input  logic [1:0]        code_i,
  input  logic              cap_v_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic              st2_v_o,
  output logic [ADDR_W-1:0] st2_addr_o,
  output logic [DATA_W-1:0] st2_data_o
);

  logic              lat_v, st1_v, st2_v;
  logic [ADDR_W-1:0] lat_a, st1_a, st2_a;
  logic [DATA_W-1:0] lat_d, st1_d, st2_d;
  move_e             mv;

  assign mv = move_e'(code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_v <= 1'b0; lat_a <= '0; lat_d <= '0;
      st1_v <= 1'b0; st1_a <= '0; st1_d <= '0;
      st2_v <= 1'b0; st2_a <= '0; st2_d <= '0;
    end else if (rise_stb_i) begin
      unique case (mv)
        MV_LATCH: begin
          lat_v <= cap_v_i; lat_a <= cap_addr_i; lat_d <= cap_data_i;
        end
        MV_ADV_BUS: begin
          st2_v <= st1_v; st2_a <= st1_a; st2_d <= st1_d;
          st1_v <= cap_v_i; st1_a <= cap_addr_i; st1_d <= cap_data_i;
        end
        MV_ADV_LATCH: begin
          st2_v <= st1_v; st2_a <= st1_a; st2_d <= st1_d;
          st1_v <= lat_v; st1_a <= lat_a; st1_d <= lat_d;
          lat_v <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign st2_v_o    = st2_v;
  assign st2_addr_o = st2_a;
  assign st2_data_o = st2_d;

  // R4
  adv_bus_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_stb_i && code_i == 2'b10) |=> (st2_v == $past(st1_v)) && (st1_v == $past(cap_v_i)));
  // R5
  adv_latch_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_stb_i && code_i == 2'b11) |=> !lat_v && (st1_v == $past(lat_v)));
  // R3
  latch_keeps_stages_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_stb_i && code_i == 2'b01) |=> $stable(st2_d) && $stable(st1_d) && $stable(st2_v));
  // R6
  no_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_stb_i && code_i == 2'b00) |=> $stable(st2_d) && $stable(st1_d) && $stable(lat_d));

endmodule

// File: rtl/iqt_start_unit.sv
module iqt_start_unit
  import iqt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int BYTE_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_stb_i,
  input  logic [1:0]        code_i,
  input  logic              st2_v_i,
  input  logic [ADDR_W-1:0] st2_addr_i,
  input  logic [DATA_W-1:0] st2_data_i,
  output logic              op_valid_o,
  output logic [BYTE_W-1:0] op_byte_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic              op_odd_o,
  output logic              irq_start_o,
  output logic              start_err_o
);

  start_e st;
  logic   is_op;

  assign st    = start_e'(code_i);
  assign is_op = fall_stb_i && (st == ST_EVEN || st == ST_ODD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_valid_o  <= 1'b0;
      op_byte_o   <= '0;
      op_addr_o   <= '0;
      op_odd_o    <= 1'b0;
      irq_start_o <= 1'b0;
      start_err_o <= 1'b0;
    end else begin
      op_valid_o  <= is_op && st2_v_i;
      start_err_o <= is_op && !st2_v_i;
      irq_start_o <= fall_stb_i && (st == ST_IRQ);
      if (is_op && st2_v_i) begin
        op_odd_o <= (st == ST_ODD);
        if (st == ST_ODD) begin
          op_byte_o <= st2_data_i[BYTE_W-1:0];
          op_addr_o <= st2_addr_i + ADDR_W'(1);
        end else begin
          op_byte_o <= st2_data_i[DATA_W-1:BYTE_W];
          op_addr_o <= st2_addr_i;
        end
      end
    end
  end

  // R12
  one_pulse_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({op_valid_o, irq_start_o, start_err_o}));
  // R12
  op_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |=> !op_valid_o);
  // R11
  op_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o || irq_start_o || start_err_o) |-> $past(fall_stb_i));
  // R10
  err_needs_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_err_o |-> !$past(st2_v_i));

endmodule

// File: rtl/iq_tracker.sv
module iq_tracker #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int BYTE_W     = DATA_W / 2,
  localparam int PW         = 2 + 1 + ADDR_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              e_i,
  input  logic              rw_i,
  input  logic [1:0]        pipe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              op_valid_o,
  output logic [BYTE_W-1:0] op_byte_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic              op_odd_o,
  output logic              irq_start_o,
  output logic              start_err_o
);

  logic              rise_stb, fall_stb;
  logic [PW-1:0]     pl;
  logic [1:0]        pipe_s;
  logic              rw_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic              cap_v;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic              st2_v;
  logic [ADDR_W-1:0] st2_addr;
  logic [DATA_W-1:0] st2_data;

  iqt_edge_sync #(.STAGES(SYNC_STAGES), .PW(PW)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .e_i        (e_i),
    .payload_i  ({pipe_i, rw_i, addr_i, data_i}),
    .rise_stb_o (rise_stb),
    .fall_stb_o (fall_stb),
    .payload_o  (pl)
  );

  assign {pipe_s, rw_s, addr_s, data_s} = pl;

  iqt_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_stb_i (fall_stb),
    .rd_i       (rw_s),
    .addr_i     (addr_s),
    .data_i     (data_s),
    .cap_v_o    (cap_v),
    .cap_addr_o (cap_addr),
    .cap_data_o (cap_data)
  );

  iqt_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_stb_i (rise_stb),
    .code_i     (pipe_s),
    .cap_v_i    (cap_v),
    .cap_addr_i (cap_addr),
    .cap_data_i (cap_data),
    .st2_v_o    (st2_v),
    .st2_addr_o (st2_addr),
    .st2_data_o (st2_data)
  );

  iqt_start_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_start (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fall_stb_i  (fall_stb),
    .code_i      (pipe_s),
    .st2_v_i     (st2_v),
    .st2_addr_i  (st2_addr),
    .st2_data_i  (st2_data),
    .op_valid_o  (op_valid_o),
    .op_byte_o   (op_byte_o),
    .op_addr_o   (op_addr_o),
    .op_odd_o    (op_odd_o),
    .irq_start_o (irq_start_o),
    .start_err_o (start_err_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(e_i) |=> !op_valid_o);

endmodule

// File: tb/iq_tracker_bench.sv
module iq_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        e = 1'b0;
  logic        rw = 1'b1;
  logic [1:0]  pipe = 2'b00;
  logic [15:0] addr = '0;
  logic [15:0] data = '0;
  logic        op_valid, op_odd, irq_start, start_err;
  logic [7:0]  op_byte;
  logic [15:0] op_addr;

  int n_tests = 0, n_fail = 0;
  int n_op, n_irq, n_err, n_wide;
  logic [7:0]  got_byte;
  logic [15:0] got_addr;
  logic        got_odd;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_tracker u_iq_tracker (
    .clk_i(clk), .rst_ni(rst_n), .e_i(e), .rw_i(rw), .pipe_i(pipe),
    .addr_i(addr), .data_i(data), .op_valid_o(op_valid), .op_byte_o(op_byte),
    .op_addr_o(op_addr), .op_odd_o(op_odd), .irq_start_o(irq_start),
    .start_err_o(start_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic observe();
    n_op = 0; n_irq = 0; n_err = 0; n_wide = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (op_valid) begin
        n_op++; got_byte = op_byte; got_addr = op_addr; got_odd = op_odd;
        if (i != 2) n_wide++;
      end
      if (irq_start) begin n_irq++; if (i != 2) n_wide++; end
      if (start_err) begin n_err++; if (i != 2) n_wide++; end
    end
  endtask

  task automatic e_fall(input logic [1:0] sc, input logic [15:0] a, input logic [15:0] d,
                        input logic rd);
    @(negedge clk);
    e = 1'b0; pipe = sc; addr = a; data = d; rw = rd;
    observe();
  endtask

  task automatic e_rise(input logic [1:0] mc);
    @(negedge clk);
    e = 1'b1; pipe = mc;
    observe();
  endtask

  task automatic expect_op(input string req, input logic [7:0] b, input logic [15:0] a,
                           input logic odd);
    chk(n_op == 1, {req, " op pulse count"}, n_op, 1);
    chk(got_byte == b, {req, " opcode byte"}, got_byte, b);
    chk(got_addr == a, {req, " opcode address"}, got_addr, a);
    chk(got_odd == odd, {req, " odd flag"}, got_odd, odd);
    chk(n_irq == 0 && n_err == 0, {req, " stray pulse"}, n_irq + n_err, 0);
    chk(n_wide == 0, "R12 pulse timing", n_wide, 0);
  endtask

  task automatic expect_err(input string req);
    chk(n_err == 1, {req, " error pulse count"}, n_err, 1);
    chk(n_op == 0 && n_irq == 0, {req, " stray pulse"}, n_op + n_irq, 0);
    chk(n_wide == 0, "R12 pulse timing", n_wide, 0);
  endtask

  task automatic expect_quiet(input string req);
    chk(n_op + n_irq + n_err == 0, {req, " no pulse"}, n_op + n_irq + n_err, 0);
  endtask

  task automatic t_reset();
    chk(!op_valid && !irq_start && !start_err, "R1 reset outputs",
        {op_valid, irq_start, start_err}, 0);
    e_rise(2'b00);  expect_quiet("R6");
    e_fall(2'b10, 16'h0F00, 16'h0000, 1'b1); expect_err("R1");
  endtask

  task automatic t_fill_even_odd();
    e_rise(2'b00);
    e_fall(2'b00, 16'h1000, 16'hA1B2, 1'b1); expect_quiet("R11");
    e_rise(2'b10);                           expect_quiet("R4");
    e_fall(2'b00, 16'h1002, 16'hC3D4, 1'b1);
    e_rise(2'b10);
    e_fall(2'b10, 16'h1004, 16'hE5F6, 1'b1); expect_op("R7", 8'hA1, 16'h1000, 1'b0);
    e_rise(2'b00);
    e_fall(2'b11, 16'h1006, 16'h0708, 1'b1); expect_op("R8", 8'hB2, 16'h1001, 1'b1);
  endtask

  task automatic t_latch_paths();
    e_rise(2'b00);
    e_fall(2'b00, 16'h2000, 16'h1122, 1'b1);
    e_rise(2'b01);                           // latch <- 2000
    e_fall(2'b10, 16'h2002, 16'h3344, 1'b1); expect_op("R3", 8'hA1, 16'h1000, 1'b0);
    e_rise(2'b10);                           // st2 <- 1002, st1 <- 2002
    e_fall(2'b10, 16'h2004, 16'h5566, 1'b1); expect_op("R4", 8'hC3, 16'h1002, 1'b0);
    e_rise(2'b11);                           // st2 <- 2002, st1 <- latch 2000
    e_fall(2'b11, 16'h2006, 16'h7788, 1'b1); expect_op("R5", 8'h44, 16'h2003, 1'b1);
    e_rise(2'b10);                           // st2 <- 2000
    e_fall(2'b10, 16'h2008, 16'h99AA, 1'b1); expect_op("R5", 8'h11, 16'h2000, 1'b0);
    e_rise(2'b00);
    e_fall(2'b11, 16'h200A, 16'hBBCC, 1'b1); expect_op("R6", 8'h22, 16'h2001, 1'b1);
  endtask

  task automatic t_irq_and_none();
    e_rise(2'b00);
    e_fall(2'b01, 16'h2100, 16'h0000, 1'b1);
    chk(n_irq == 1, "R9 irq pulse count", n_irq, 1);
    chk(n_op == 0 && n_err == 0, "R9 no opcode", n_op + n_err, 0);
    e_rise(2'b00);
    e_fall(2'b00, 16'h2102, 16'h0000, 1'b1); expect_quiet("R11");
  endtask

  task automatic t_write_cycle();
    e_rise(2'b00);
    e_fall(2'b00, 16'h3000, 16'hDEAD, 1'b0);
    e_rise(2'b10);                           // st1 <- invalid write word
    e_fall(2'b00, 16'h3002, 16'hBEEF, 1'b1);
    e_rise(2'b10);                           // st2 invalid
    e_fall(2'b10, 16'h3004, 16'h0000, 1'b1); expect_err("R2");
    e_rise(2'b10);                           // st2 <- 3002
    e_fall(2'b11, 16'h3006, 16'h0000, 1'b1); expect_op("R2", 8'hEF, 16'h3003, 1'b1);
  endtask

  task automatic t_latch_drained();
    e_rise(2'b00);
    e_fall(2'b00, 16'h4000, 16'h1357, 1'b1);
    e_rise(2'b01);                           // latch <- 4000
    e_fall(2'b00, 16'h4002, 16'h0000, 1'b1);
    e_rise(2'b11);                           // st1 <- latch, latch emptied
    e_fall(2'b00, 16'h4004, 16'h0000, 1'b1);
    e_rise(2'b11);                           // st2 <- 4000, st1 <- invalid
    e_fall(2'b10, 16'h4006, 16'h0000, 1'b1); expect_op("R5", 8'h13, 16'h4000, 1'b0);
    e_rise(2'b10);                           // st2 <- invalid
    e_fall(2'b11, 16'h4008, 16'h0000, 1'b1); expect_err("R10");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_fill_even_odd();
    t_latch_paths();
    t_irq_and_none();
    t_write_cycle();
    t_latch_drained();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R12 watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule